// File: doc/BRIEF.md
# DMA Request Routing and Masking Unit

This unit sits between a bank of peripheral interrupt lines and a multi-channel DMA engine. Each source line is steered either to the processor's interrupt controller or into a pool of DMA requests, never to both at once. Each DMA channel watches one pooled line, named by its own source-select field. A fixed-priority arbiter hands a single grant to one requesting channel and keeps it until the data mover reports that the transfer is finished.

When a transfer completes, the unit raises the channel's completion interrupt. For sources marked as needing it, the unit also sends a one-cycle clear pulse back to the source. A serial unit that detects a receive error (parity, framing or overrun, with receive interrupts enabled) or a chip-select error (with that interrupt enabled) raises a stop line. The channel serving that source then loses its grant and stays masked until software clears the mask. Which sources can use DMA at all, and which need a clear pulse, are fixed by build parameters.

Configuration uses a plain write port. Address 0 holds the steering vector. Address 1+c holds channel c: source select in bits [SELW-1:0] and enable in bit SELW, where SELW is 5 for 32 sources.

Top module: `dreq_router`

## Requirements
- R1: `cpu_irq[i]` equals `src_irq[i]` while source i is steered to the CPU, and is 0 while source i is steered to the DMA pool (steering bit 1).
- R2: A source whose `DMA_CAP` bit is 0 always stays steered to the CPU, whatever value is written to its steering bit.
- R3: Channel c requests only while it is enabled, it is not masked, and the pooled line named by its source select is high.
- R4: At most one grant bit is high. When no grant is held, the lowest-index requesting channel is granted at the next clock edge.
- R5: A grant is held unchanged while higher-priority requests arrive, and it drops at the edge where `xfer_done` for the granted channel is sampled high.
- R6: After a completed transfer, `src_clr` pulses for exactly one cycle on the channel's selected source, in the cycle after `xfer_done`, and only if that source's `NEED_CLR` bit is 1.
- R7: `ch_irq[c]` pulses for one cycle, in the same cycle as the clear pulse, for each transfer that channel c completes.
- R8: No grant is issued in the cycle in which the completion pulses are high. Arbitration resumes on the edge after that cycle.
- R9: A high `stop_src` line on the source of an enabled channel sets that channel's mask. If the channel holds the grant, the grant drops at the next edge with no completion interrupt and no clear pulse.
- R10: A masked channel is never granted. Its mask stays set until a `mask_clr` pulse for that channel, and a stop in the same cycle as `mask_clr` leaves the mask set.
- R11: A write to an address above NCH changes no configuration.
- R12: Reset steers every source to the CPU, disables every channel, clears all masks, and leaves grant, completion and clear outputs at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | NSRC | Peripheral interrupt lines |
| cpu_irq | output | NSRC | Lines passed on to the interrupt controller |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDRW | Configuration address (0 steering, 1+c channel c) |
| cfg_wdata | input | DW | Configuration write data |
| stop_src | input | NSRC | Per-source transfer stop requests |
| mask_clr | input | NCH | Per-channel mask clear pulses |
| xfer_done | input | NCH | Transfer-complete strobes from the data mover |
| grant | output | NCH | One-hot channel grant |
| ch_irq | output | NCH | Per-channel completion interrupt pulses |
| src_clr | output | NSRC | Request-clear pulses back to sources |

## Verification
On every cycle the assertions check the following: exclusive routing of each line, a one-hot grant, a grant held until completion or stop, the completion interrupt tracking the completed transfer one cycle later, clear pulses only after a completion, the idle cycle after completion, a grant dropped after a stop, and no grant given to a masked channel. Some behaviours show only through the bench's scenarios. The lowest-index winner for every one of the 255 request patterns over the eight channels is one of them. The others are the per-source choice of clear pulse, the forced CPU steering of sources that cannot use DMA, the effect of changing a channel's source select, a mask that persists until cleared, and writes to unused addresses.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam int MAXW = 32;
  typedef logic [MAXW-1:0] vec_t;

  // isolate the lowest set bit of a vector
  function automatic vec_t lowest_set(input vec_t v);
    return v & (~v + vec_t'(1));
  endfunction

  // one-hot image of a source index
  function automatic vec_t src_onehot(input logic [4:0] s);
    return vec_t'(1) << s;
  endfunction
endpackage

// File: rtl/dreq_cfg_regs.sv
module dreq_cfg_regs #(
  parameter int NSRC = 32,
  parameter int NCH = 8,
  parameter int DW = 32,
  parameter int SELW = 5,
  parameter int ADDRW = 4,
  parameter logic [31:0] DMA_CAP = 32'hFFFF_FFFF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [ADDRW-1:0]          addr,
  input  logic [DW-1:0]             wdata,
  output logic [NSRC-1:0]           steer_eff,
  output logic [NCH-1:0][SELW-1:0]  sel,
  output logic [NCH-1:0]            en
);
  logic [NSRC-1:0] steer_q;

  always_ff @(posedge clk) begin
    if (!rst_n) steer_q <= '0;
    else if (we && addr == '0) steer_q <= wdata[NSRC-1:0] & DMA_CAP[NSRC-1:0];
  end
  assign steer_eff = steer_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SELW-1:0] s_q;
    logic            e_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s_q <= '0;
        e_q <= 1'b0;
      end else if (we && addr == ADDRW'(c + 1)) begin
        s_q <= wdata[SELW-1:0];
        e_q <= wdata[SELW];
      end
    end
    assign sel[c] = s_q;
    assign en[c]  = e_q;
  end
endmodule

// File: rtl/dreq_chan_slot.sv
module dreq_chan_slot #(
  parameter int NSRC = 32,
  parameter int SELW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pool,
  input  logic [NSRC-1:0] stop_src,
  input  logic [SELW-1:0] sel,
  input  logic            en,
  input  logic            mask_clr,
  output logic            req,
  output logic            stop_hit,
  output logic            masked
);
  logic mask_q;

  assign stop_hit = en & stop_src[sel];
  assign req      = en & ~mask_q & pool[sel];
  assign masked   = mask_q;

  // a stop wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rst_n)        mask_q <= 1'b0;
    else if (stop_hit) mask_q <= 1'b1;
    else if (mask_clr) mask_q <= 1'b0;
  end
endmodule

// File: rtl/dreq_arb.sv
module dreq_arb
  import dreq_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int NCH = 8,
  parameter int SELW = 5,
  parameter logic [31:0] NEED_CLR = 32'h0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            req,
  input  logic [NCH-1:0]            stop_hit,
  input  logic [NCH-1:0]            xfer_done,
  input  logic [NCH-1:0][SELW-1:0]  sel,
  output logic [NCH-1:0]            grant,
  output logic [NCH-1:0]            ch_irq,
  output logic [NSRC-1:0]           src_clr,
  output logic [NCH-1:0]            done_evt
);
  logic [NCH-1:0]  grant_q, irq_q, pick;
  logic [NSRC-1:0] clr_q, clr_d;
  logic            abort;
  vec_t            pick_w, oh_all;

  assign pick_w   = lowest_set(vec_t'(req & ~stop_hit));
  assign pick     = pick_w[NCH-1:0];
  assign done_evt = grant_q & xfer_done & ~stop_hit;
  assign abort    = |(grant_q & stop_hit);

  always_comb begin
    oh_all = '0;
    for (int c = 0; c < NCH; c++)
      if (done_evt[c]) oh_all = oh_all | src_onehot(5'(sel[c]));
    clr_d = oh_all[NSRC-1:0] & NEED_CLR[NSRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      irq_q   <= '0;
      clr_q   <= '0;
    end else begin
      irq_q <= done_evt;
      clr_q <= clr_d;
      if (grant_q != '0) begin
        if ((done_evt != '0) || abort) grant_q <= '0;
      end else if (irq_q == '0) begin
        grant_q <= pick;
      end
    end
  end

  assign grant   = grant_q;
  assign ch_irq  = irq_q;
  assign src_clr = clr_q;
endmodule

// File: rtl/dreq_router.sv
module dreq_router
  import dreq_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int NCH = 8,
  parameter int DW = 32,
  parameter logic [31:0] DMA_CAP = 32'hFFFF_FFFF,
  parameter logic [31:0] NEED_CLR = 32'h0000_0000,
  localparam int SELW = $clog2(NSRC),
  localparam int ADDRW = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_irq,
  output logic [NSRC-1:0]   cpu_irq,
  input  logic              cfg_we,
  input  logic [ADDRW-1:0]  cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic [NSRC-1:0]   stop_src,
  input  logic [NCH-1:0]    mask_clr,
  input  logic [NCH-1:0]    xfer_done,
  output logic [NCH-1:0]    grant,
  output logic [NCH-1:0]    ch_irq,
  output logic [NSRC-1:0]   src_clr
);
  logic [NSRC-1:0]          steer_eff, pool;
  logic [NCH-1:0][SELW-1:0] sel;
  logic [NCH-1:0]           en, ch_req, stop_hit, mask, done_evt;

  dreq_cfg_regs #(
    .NSRC(NSRC), .NCH(NCH), .DW(DW), .SELW(SELW), .ADDRW(ADDRW), .DMA_CAP(DMA_CAP)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .steer_eff(steer_eff), .sel(sel), .en(en)
  );

  assign pool    = src_irq & steer_eff;
  assign cpu_irq = src_irq & ~steer_eff;

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    dreq_chan_slot #(.NSRC(NSRC), .SELW(SELW)) u_slot (
      .clk(clk), .rst_n(rst_n), .pool(pool), .stop_src(stop_src),
      .sel(sel[c]), .en(en[c]), .mask_clr(mask_clr[c]),
      .req(ch_req[c]), .stop_hit(stop_hit[c]), .masked(mask[c])
    );
  end

  dreq_arb #(.NSRC(NSRC), .NCH(NCH), .SELW(SELW), .NEED_CLR(NEED_CLR)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(ch_req), .stop_hit(stop_hit),
    .xfer_done(xfer_done), .sel(sel), .grant(grant), .ch_irq(ch_irq),
    .src_clr(src_clr), .done_evt(done_evt)
  );
endmodule

// File: rtl/dreq_router_chk.sv
module dreq_router_chk #(
  parameter int NSRC = 32,
  parameter int NCH = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_irq,
  input logic [NSRC-1:0] cpu_irq,
  input logic [NSRC-1:0] steer_eff,
  input logic [NCH-1:0]  grant,
  input logic [NCH-1:0]  xfer_done,
  input logic [NCH-1:0]  stop_hit,
  input logic [NCH-1:0]  ch_irq,
  input logic [NSRC-1:0] src_clr,
  input logic [NCH-1:0]  mask,
  input logic [NCH-1:0]  done_evt
);
  p_route_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_irq & steer_eff) == '0) && ((cpu_irq & ~src_irq) == '0));

  p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_grant_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && (grant & (xfer_done | stop_hit)) == '0) |=> grant == $past(grant));

  p_clear_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_clr != '0) |-> $past(done_evt != '0));

  p_irq_tracks_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ch_irq == $past(done_evt));

  p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_irq != '0) |=> grant == '0);

  p_stop_drops_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & stop_hit) != '0) |=> (grant == '0 && ch_irq == '0));

  p_masked_not_granted_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~$past(grant) & $past(mask)) == '0);
endmodule

bind dreq_router dreq_router_chk #(.NSRC(NSRC), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .cpu_irq(cpu_irq),
  .steer_eff(steer_eff), .grant(grant), .xfer_done(xfer_done),
  .stop_hit(stop_hit), .ch_irq(ch_irq), .src_clr(src_clr),
  .mask(mask), .done_evt(done_evt)
);

// File: tb/dreq_router_test.sv
`timescale 1ns/1ps
module dreq_router_test;
  localparam logic [31:0] CAP  = 32'hFFFF_00FF;
  localparam logic [31:0] NEED = 32'h0010_000F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_irq = '0, cpu_irq, stop_src = '0, src_clr;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  mask_clr = '0, xfer_done = '0, grant, ch_irq;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dreq_router #(.NSRC(32), .NCH(8), .DW(32), .DMA_CAP(CAP), .NEED_CLR(NEED)) uut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .cpu_irq(cpu_irq),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .stop_src(stop_src), .mask_clr(mask_clr), .xfer_done(xfer_done),
    .grant(grant), .ch_irq(ch_irq), .src_clr(src_clr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  function automatic logic [7:0] low8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 8'(1) << i;
    return '0;
  endfunction

  function automatic logic [31:0] clr_of(input int s);
    return NEED[s] ? (32'h1 << s) : 32'h0;
  endfunction

  // finish a transfer on channel index ch: done strobe, then two quiet cycles
  task automatic finish_xfer(input int ch, input int s);
    @(negedge clk); xfer_done = 8'(1) << ch; src_irq = '0;
    @(negedge clk); xfer_done = '0;
    chk(ch_irq == (8'(1) << ch), "R7 completion pulse", 32'(ch_irq), 32'(8'(1) << ch));
    chk(src_clr == clr_of(s), "R6 clear pulse", src_clr, clr_of(s));
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    logic [31:0] steers [4];
    pats = '{32'hFFFF_FFFF, 32'h5A5A_A5A5, 32'h0123_4567, 32'h8000_0001};
    steers = '{32'hFFFF_FFFF, 32'h0, 32'h1234_5678, 32'hF0F0_F0F0};

    // R12 reset state
    repeat (3) @(negedge clk);
    chk(grant == 0 && ch_irq == 0 && src_clr == 0, "R12 reset outputs", {grant, ch_irq, 16'h0}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); src_irq = 32'hA5A5_A5A5;
    @(negedge clk);
    chk(cpu_irq == 32'hA5A5_A5A5, "R12 steer reset to cpu", cpu_irq, 32'hA5A5_A5A5);

    // R11 unused addresses
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    @(negedge clk); src_irq = 32'hFFFF_FFFF;
    @(negedge clk);
    chk(cpu_irq == 32'hFFFF_FFFF, "R11 unused write ignored", cpu_irq, 32'hFFFF_FFFF);
    chk(grant == 0, "R11 no channel enabled", 32'(grant), 32'h0);

    // R1 / R2 routing sweep
    foreach (steers[k]) begin
      wr(4'd0, steers[k]);
      foreach (pats[j]) begin
        @(negedge clk); src_irq = pats[j];
        @(negedge clk);
        chk(cpu_irq == (pats[j] & ~(steers[k] & CAP)), "R1 routing", cpu_irq, pats[j] & ~(steers[k] & CAP));
      end
    end
    wr(4'd0, 32'hFFFF_FFFF);
    @(negedge clk); src_irq = 32'h0000_FF00;
    @(negedge clk);
    chk(cpu_irq == 32'h0000_FF00, "R2 non-capable stays cpu", cpu_irq, 32'h0000_FF00);
    @(negedge clk); src_irq = '0;

    // channel c watches source c, enabled (enable bit 5)
    for (int c = 0; c < 8; c++) wr(4'(c + 1), 32'h20 | c);

    // R4/R5/R6/R7/R8 sweep over all request patterns
    for (int p = 1; p < 256; p++) begin
      logic [7:0] w;
      int wi;
      w = low8(8'(p));
      wi = 0;
      for (int i = 0; i < 8; i++) if (w[i]) wi = i;
      @(negedge clk); src_irq = 32'(p);
      @(negedge clk);
      chk(grant == w, "R4 lowest index wins", 32'(grant), 32'(w));
      xfer_done = grant;
      @(negedge clk); xfer_done = '0;
      chk(grant == 0, "R5 grant drops on done", 32'(grant), 32'h0);
      chk(ch_irq == w, "R7 completion pulse", 32'(ch_irq), 32'(w));
      chk(src_clr == clr_of(wi), "R6 clear pulse", src_clr, clr_of(wi));
      @(negedge clk);
      chk(grant == 0, "R8 no grant in pulse cycle", 32'(grant), 32'h0);
      chk(src_clr == 0 && ch_irq == 0, "R6 single-cycle pulse", {ch_irq, src_clr[23:0]}, 32'h0);
      @(negedge clk);
      chk(grant == w, "R4 rearbitration", 32'(grant), 32'(w));
      finish_xfer(wi, wi);
    end

    // R5 grant held while a higher priority request appears
    @(negedge clk); src_irq = 32'h20;
    @(negedge clk); src_irq = 32'h21;
    repeat (3) @(negedge clk);
    chk(grant == 8'h20, "R5 grant held", 32'(grant), 32'h20);
    xfer_done = 8'h20; src_irq = 32'h1;
    @(negedge clk); xfer_done = '0;
    chk(src_clr == 0, "R6 no clear for unflagged source", src_clr, 32'h0);
    @(negedge clk); @(negedge clk);
    chk(grant == 8'h01, "R4 next winner after hold", 32'(grant), 32'h1);
    finish_xfer(0, 0);

    // R9 stop on granted channel, R10 mask persistence
    @(negedge clk); src_irq = 32'h4;
    @(negedge clk);
    chk(grant == 8'h04, "R9 setup grant", 32'(grant), 32'h4);
    stop_src = 32'h4;
    @(negedge clk); stop_src = '0;
    chk(grant == 0, "R9 stop drops grant", 32'(grant), 32'h0);
    chk(ch_irq == 0 && src_clr == 0, "R9 no completion on stop", {ch_irq, src_clr[23:0]}, 32'h0);
    @(negedge clk); @(negedge clk);
    chk(grant == 0, "R10 masked channel not granted", 32'(grant), 32'h0);
    src_irq = 32'h6;
    @(negedge clk);
    chk(grant == 8'h02, "R10 other channel unaffected", 32'(grant), 32'h2);
    finish_xfer(1, 1);
    @(negedge clk); src_irq = 32'h4; mask_clr = 8'h04;
    @(negedge clk); mask_clr = '0;
    @(negedge clk);
    chk(grant == 8'h04, "R10 mask cleared", 32'(grant), 32'h4);
    finish_xfer(2, 2);

    // R10 stop wins over simultaneous mask clear (idle channel 3)
    @(negedge clk); stop_src = 32'h8; mask_clr = 8'h08;
    @(negedge clk); stop_src = '0; mask_clr = '0; src_irq = 32'h8;
    @(negedge clk); @(negedge clk);
    chk(grant == 0, "R10 stop beats clear", 32'(grant), 32'h0);
    mask_clr = 8'h08;
    @(negedge clk); mask_clr = '0;
    @(negedge clk);
    chk(grant == 8'h08, "R10 released after clear", 32'(grant), 32'h8);
    finish_xfer(3, 3);

    // R3 disabled channel and changed source select
    wr(4'd1, 32'h00);
    @(negedge clk); src_irq = 32'h1;
    @(negedge clk); @(negedge clk);
    chk(grant == 0, "R3 disabled channel idle", 32'(grant), 32'h0);
    @(negedge clk); src_irq = '0;
    wr(4'd2, 32'h20 | 20);
    @(negedge clk); src_irq = 32'h2;
    @(negedge clk); @(negedge clk);
    chk(grant == 0, "R3 old source ignored", 32'(grant), 32'h0);
    src_irq = 32'h0010_0000;
    @(negedge clk);
    chk(grant == 8'h02, "R3 new source selected", 32'(grant), 32'h2);
    finish_xfer(1, 20);

    // R2 channel on a non-capable source never requests
    wr(4'd7, 32'h20 | 9);
    @(negedge clk); src_irq = 32'h200;
    @(negedge clk); @(negedge clk);
    chk(grant == 0, "R2 non-capable source gives no request", 32'(grant), 32'h0);
    chk(cpu_irq == 32'h200, "R2 line reaches cpu", cpu_irq, 32'h200);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule